// File: doc/BRIEF.md
# Polled Pad Status Monitor

This block keeps a processor informed about a game pad without the processor having to poll it. A free-running interval timer decides when to sample. When the interval expires, the block hands a read-buttons request (code 0x01) to a single-wire transceiver. It then waits for the 32-bit reply and compares the reply with the status word it stored last time. If the reply differs, the stored word is replaced and a sticky change flag is set. If the reply is equal, or the transceiver reports a timeout, nothing is recorded. In every case the block goes back to idle and the interval starts again.

Both transceiver channels use valid/ready handshakes. On the request channel, `req_valid` stays high and `req_cmd` stays stable until the transceiver accepts the request with `req_ready`. The transceiver may hold `req_ready` low for as long as it needs. On the reply channel, `rsp_ready` is high only while a reply is expected. A reply counts only in a cycle where `rsp_valid` and `rsp_ready` are both high. The register bus and `irq` are plain signals. The transceiver is responsible for all line-level timing.

The stored word holds the pad fields exactly as received. Bits 0-7 and 10-15 are active-high buttons. Bits 16-31 carry the two stick axes as signed values from -80 to 80.

Top module: `pad_poll_monitor`

## Requirements
- R1: After reset: `req_valid`, `rsp_ready` and `irq` are 0; the status register reads 0; the interval register reads `DEF_INTERVAL`; the control register reads 0.
- R2: The idle phase lasts max(interval,1) clock cycles. After it, `req_valid` rises with `req_cmd` = 0x01.
- R3: While `req_ready` is low, `req_valid` stays high and `req_cmd` stays unchanged. `rsp_ready` is high from the cycle after the request is accepted until a reply is taken, and at no other time.
- R4: If a reply is taken with `rsp_timeout`=0 and its data differs from the stored status, the stored status takes the reply's data and the change flag is set.
- R5: If a reply is taken with data equal to the stored status, neither the status nor the flag changes.
- R6: If a reply is taken with `rsp_timeout`=1, neither the status nor the flag changes, whatever the data is.
- R7: The control register is at byte offset 0x8. Bit 0 is the change flag; writing 1 to it clears it, but a change detected in the same cycle wins. Bit 1 is the interrupt enable. `irq` = flag AND enable.
- R8: Reads return data on `reg_rdata` one cycle after `reg_rd`, which then holds until the next read. Offsets are decoded from address bits 3:2: 0x0 is status (writes ignored), 0x4 is the interval, 0x8 is control, and 0xC reads 0.
- R9: The stored status keeps all 32 reply bits unaltered, including bits 8-9 and negative axis values in bits 16-31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | output | 1 | Request to transceiver pending |
| req_ready | input | 1 | Transceiver accepts request |
| req_cmd | output | 8 | Request code, 0x01 |
| rsp_valid | input | 1 | Reply from transceiver present |
| rsp_ready | output | 1 | Block waiting for reply |
| rsp_timeout | input | 1 | Reply is a timeout, data invalid |
| rsp_data | input | DATA_W | Reply status word |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after read |
| irq | output | 1 | Change interrupt |

## Verification
The assertions check the following on every cycle:
- request hold under back-pressure;
- the request-to-reply phase order;
- that each timer expiry leads to a request;
- that timeouts leave the status frozen;
- that a differing reply sets the flag;
- that the clear write works;
- that writes to the status offset are ignored.

Some behaviour only the bench scenarios can show. These are the exact idle length for given intervals (including 0), the read latency and the read map, the set-beats-clear collision, the enable gating of `irq`, and bit-exact storage of negative axes. The bench's cycle model compares the handshake outputs, `irq` and `reg_rdata` on every clock.

// File: rtl/pad_poll_pkg.sv
package pad_poll_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_WAIT = 2'd2
  } poll_phase_t;

  localparam logic [7:0] CMD_READ_BUTTONS = 8'h01;
  localparam int REG_W = 32;

  localparam logic [1:0] WSEL_STATUS   = 2'd0;
  localparam logic [1:0] WSEL_INTERVAL = 2'd1;
  localparam logic [1:0] WSEL_CTRL     = 2'd2;

  localparam int CTRL_FLAG_BIT = 0;
  localparam int CTRL_EN_BIT   = 1;
endpackage

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int IVL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [IVL_W-1:0] interval,
  output logic             expire
);
  logic [IVL_W-1:0] cnt_q;
  logic [IVL_W-1:0] limit;

  always_comb begin
    limit = interval;
    if (interval == '0) limit = {{(IVL_W-1){1'b0}}, 1'b1};
  end

  assign expire = run && (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || expire) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R2: one expiry ends the idle phase, so it never repeats back to back
  a_r2_single_expire: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

// File: rtl/poll_seq.sv
module poll_seq
  import pad_poll_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  output logic              run,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [7:0]        req_cmd,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic              rsp_timeout,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              smp_valid,
  output logic              smp_timeout,
  output logic [DATA_W-1:0] smp_data
);
  poll_phase_t ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (expire)    ph_d = PH_REQ;
      PH_REQ:  if (req_ready) ph_d = PH_WAIT;
      PH_WAIT: if (rsp_valid) ph_d = PH_IDLE;
      default:                ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign run         = (ph_q == PH_IDLE);
  assign req_valid   = (ph_q == PH_REQ);
  assign req_cmd     = CMD_READ_BUTTONS;
  assign rsp_ready   = (ph_q == PH_WAIT);
  assign smp_valid   = rsp_valid && rsp_ready;
  assign smp_timeout = rsp_timeout;
  assign smp_data    = rsp_data;

  // R3: request holds under back-pressure
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_cmd));
  // R3: accepted request leads to waiting for the reply
  a_r3_wait_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_ready && !req_valid);
  // R2: timer expiry starts a request
  a_r2_expire_to_req: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> req_valid);
  // R3: a taken reply returns to idle
  a_r3_reply_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> run && !rsp_ready);
endmodule

// File: rtl/poll_regs.sv
module poll_regs
  import pad_poll_pkg::*;
#(
  parameter int              DATA_W       = 32,
  parameter int              IVL_W        = 32,
  parameter int              ADDR_W       = 4,
  parameter logic [IVL_W-1:0] DEF_INTERVAL = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              smp_valid,
  input  logic              smp_timeout,
  input  logic [DATA_W-1:0] smp_data,
  output logic [IVL_W-1:0]  interval,
  output logic              irq
);
  localparam int SEL_W = 2;

  logic [DATA_W-1:0] status_q;
  logic [IVL_W-1:0]  ivl_q;
  logic              flag_q, en_q;
  logic [REG_W-1:0]  rdata_q, rd_mux;
  logic [SEL_W-1:0]  wsel;
  logic              changed, clr_req;

  assign wsel    = reg_addr[SEL_W+1:2];
  assign changed = smp_valid && !smp_timeout && (smp_data != status_q);
  assign clr_req = reg_wr && (wsel == WSEL_CTRL) && reg_wdata[CTRL_FLAG_BIT];

  always_comb begin
    rd_mux = '0;
    unique case (wsel)
      WSEL_STATUS:   rd_mux[DATA_W-1:0] = status_q;
      WSEL_INTERVAL: rd_mux[IVL_W-1:0]  = ivl_q;
      WSEL_CTRL: begin
        rd_mux[CTRL_FLAG_BIT] = flag_q;
        rd_mux[CTRL_EN_BIT]   = en_q;
      end
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ivl_q    <= DEF_INTERVAL;
      flag_q   <= 1'b0;
      en_q     <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (reg_rd) rdata_q <= rd_mux;
      if (reg_wr && wsel == WSEL_INTERVAL) ivl_q <= reg_wdata[IVL_W-1:0];
      if (reg_wr && wsel == WSEL_CTRL)     en_q  <= reg_wdata[CTRL_EN_BIT];
      if (changed) begin
        status_q <= smp_data;
        flag_q   <= 1'b1;
      end else if (clr_req) begin
        flag_q   <= 1'b0;
      end
    end
  end

  assign reg_rdata = rdata_q;
  assign interval  = ivl_q;
  assign irq       = flag_q && en_q;

  // R6: timeout reply leaves status and flag alone
  a_r6_timeout_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && smp_timeout |=> $stable(status_q) && ($stable(flag_q) || !flag_q));
  // R4: differing reply is stored and flagged
  a_r4_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_timeout && (smp_data != status_q) |=> flag_q && (status_q == $past(smp_data)));
  // R5: equal reply does not raise the flag
  a_r5_equal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && (smp_data == status_q) && !flag_q |=> !flag_q);
  // R7: clear write drops the flag when no change collides
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr[3:2] == 2'd2) && reg_wdata[0] && !smp_valid |=> !flag_q);
  // R8: status offset ignores writes
  a_r8_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr[3:2] == 2'd0) && !smp_valid |=> $stable(status_q));
endmodule

// File: rtl/pad_poll_monitor.sv
module pad_poll_monitor
  import pad_poll_pkg::*;
#(
  parameter int              DATA_W       = 32,
  parameter int              IVL_W        = 32,
  parameter int              ADDR_W       = 4,
  parameter logic [IVL_W-1:0] DEF_INTERVAL = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [7:0]        req_cmd,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic              rsp_timeout,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  logic              run, expire;
  logic [IVL_W-1:0]  interval;
  logic              smp_valid, smp_timeout;
  logic [DATA_W-1:0] smp_data;

  poll_timer #(.IVL_W(IVL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .interval(interval), .expire(expire)
  );

  poll_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .run(run),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_timeout(rsp_timeout),
    .rsp_data(rsp_data), .smp_valid(smp_valid), .smp_timeout(smp_timeout),
    .smp_data(smp_data)
  );

  poll_regs #(
    .DATA_W(DATA_W), .IVL_W(IVL_W), .ADDR_W(ADDR_W), .DEF_INTERVAL(DEF_INTERVAL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .smp_valid(smp_valid), .smp_timeout(smp_timeout), .smp_data(smp_data),
    .interval(interval), .irq(irq)
  );
endmodule

// File: tb/pad_poll_monitor_tb.sv
module pad_poll_monitor_tb_top;
  localparam int DEF_IVL = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid, req_ready = 1'b0;
  logic [7:0]  req_cmd;
  logic        rsp_valid = 1'b0, rsp_ready, rsp_timeout = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  pad_poll_monitor #(.DEF_INTERVAL(32'(DEF_IVL))) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_timeout(rsp_timeout), .rsp_data(rsp_data), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int          m_ph = 0, m_cnt = 0;
  longint      m_ivl = DEF_IVL;
  logic [31:0] m_status = '0, m_rdata = '0;
  bit          m_flag = 0, m_en = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_ivl = DEF_IVL; m_status = '0;
      m_rdata = '0; m_flag = 0; m_en = 0;
    end else begin
      bit chg, clr;
      longint lim;
      if (reg_rd) begin
        case (reg_addr[3:2])
          2'd0: m_rdata = m_status;
          2'd1: m_rdata = 32'(m_ivl);
          2'd2: m_rdata = {30'd0, m_en, m_flag};
          default: m_rdata = '0;
        endcase
      end
      chg = 0;
      clr = reg_wr && reg_addr[3:2] == 2'd2 && reg_wdata[0];
      lim = (m_ivl == 0) ? 1 : m_ivl;
      case (m_ph)
        0: if (m_cnt + 1 >= lim) begin m_ph = 1; m_cnt = 0; end else m_cnt++;
        1: if (req_ready) m_ph = 2;
        default: if (rsp_valid) begin
          if (!rsp_timeout && rsp_data != m_status) chg = 1;
          m_ph = 0; m_cnt = 0;
        end
      endcase
      if (reg_wr && reg_addr[3:2] == 2'd1) m_ivl = reg_wdata;
      if (reg_wr && reg_addr[3:2] == 2'd2) m_en = reg_wdata[1];
      if (chg) begin m_status = rsp_data; m_flag = 1; end
      else if (clr) m_flag = 0;
    end
  end

  always @(negedge clk) if (cmp_on) begin
    check(req_valid == (m_ph == 1), "R2/R3 req_valid", req_valid, m_ph == 1);
    check(rsp_ready == (m_ph == 2), "R3 rsp_ready", rsp_ready, m_ph == 2);
    if (req_valid) check(req_cmd == 8'h01, "R2 req_cmd", req_cmd, 8'h01);
    check(irq == (m_flag && m_en), "R7 irq", irq, m_flag && m_en);
    check(reg_rdata == m_rdata, "R8 reg_rdata", reg_rdata, m_rdata);
  end

  always @(posedge clk) if (cyc > 150000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic serve(input int hold, input int lat, input logic [31:0] d,
                       input bit to, input bit clr_same);
    while (!req_valid) @(negedge clk);
    repeat (hold) @(negedge clk);
    req_ready = 1; @(negedge clk); req_ready = 0;
    repeat (lat) @(negedge clk);
    rsp_valid = 1; rsp_data = d; rsp_timeout = to;
    if (clr_same) begin reg_wr = 1; reg_addr = 4'h8; reg_wdata = 32'h3; end
    @(negedge clk);
    rsp_valid = 0; rsp_timeout = 0; reg_wr = 0;
  endtask

  task automatic gap(input int exp, input string tag);
    int n = 0;
    while (!req_valid) begin n++; @(negedge clk); end
    check(n == exp, tag, n, exp);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1; cmp_on = 1;
    // R1 reset values
    check(!req_valid && !irq, "R1 outputs", {req_valid, irq}, 0);
    rd(4'h0, v); check(v == 0, "R1 status", v, 0);
    rd(4'h4, v); check(v == DEF_IVL, "R1 interval", v, DEF_IVL);
    rd(4'h8, v); check(v == 0, "R1 ctrl", v, 0);
    wr(4'h4, 16); wr(4'h8, 32'h2);
    // R4 change with enable on
    serve(0, 2, 32'h0000_1234, 0, 0);
    rd(4'h0, v); check(v == 32'h1234, "R4 status", v, 32'h1234);
    rd(4'h8, v); check(v == 3, "R4 flag", v, 3);
    check(irq == 1, "R7 irq set", irq, 1);
    wr(4'h8, 32'h3);
    check(irq == 0, "R7 clear", irq, 0);
    // R5 equal with back-pressure (R3)
    serve(4, 1, 32'h0000_1234, 0, 0);
    rd(4'h8, v); check(v == 2, "R5 no flag", v, 2);
    // R6 timeout with differing data
    serve(0, 3, 32'hDEAD_BEEF, 1, 0);
    rd(4'h0, v); check(v == 32'h1234, "R6 status kept", v, 32'h1234);
    rd(4'h8, v); check(v == 2, "R6 no flag", v, 2);
    // R9 negative axes and bits 8-9, enable off
    wr(4'h8, 32'h0);
    serve(0, 1, 32'hB050_03A5, 0, 0);
    rd(4'h0, v); check(v == 32'hB050_03A5, "R9 verbatim", v, 32'hB050_03A5);
    check(irq == 0, "R7 gated", irq, 0);
    rd(4'h8, v); check(v == 1, "R7 flag w/o enable", v, 1);
    wr(4'h8, 32'h2);
    check(irq == 1, "R7 enable", irq, 1);
    // R8 status read-only, unmapped reads zero
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); check(v == 32'hB050_03A5, "R8 status ro", v, 32'hB050_03A5);
    rd(4'hC, v); check(v == 0, "R8 unmapped", v, 0);
    rd(4'h4, v); check(v == 16, "R8 interval", v, 16);
    // R7 set wins over clear in same cycle
    serve(0, 1, 32'h0001_0000, 0, 1);
    rd(4'h8, v); check(v == 3, "R7 set wins", v, 3);
    // R2 idle length
    wr(4'h4, 5);
    serve(0, 0, 32'h0001_0000, 0, 0);
    gap(5, "R2 interval 5");
    wr(4'h4, 0);
    serve(0, 0, 32'h0001_0000, 0, 0);
    gap(1, "R2 interval 0");
    serve(2, 0, 32'h0001_0000, 0, 0);
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule